// File: doc/BRIEF.md
# Audio Effects DSP Execution Unit

This block is the arithmetic core of a small audio effects processor. Each cycle it may accept one instruction: a 4-bit opcode and three signed 32-bit operands called A, X and Y. One clock edge later it presents a 32-bit result, a condition-code word describing that result, and, for the conditional-skip opcode, a skip request with a count. The unit also owns an internal accumulator and a sticky saturation flag.

The instruction set covers fractional (Q1.31) multiply-accumulate, with either clamping or wraparound, and integer multiply-accumulate. It also provides a three-way add, a move that feeds the internal accumulator, interpolation between two values, signed limit and compare-and-invert operations, a mask-and-toggle bitwise operation, and the skip test. The instruction sequencer, the register file and the delay memory live outside. The two converter opcodes (0xC and 0xD) are handled elsewhere and pass A through unchanged.

All arithmetic is carried in a 68-bit signed intermediate, so no product or sum is cut short before saturation is decided.

Top module: `fxdsp_alu`

## Requirements
- R1: An instruction sampled with `in_valid` high at a rising edge sets `out_valid` high for exactly the next cycle, with `result`, `ccode`, `skip_req` and `skip_count` for that instruction. When `in_valid` is low, `out_valid` falls and `result` and `ccode` hold their values. After reset every output is zero.
- R2: Opcodes 0x0–0x3 give A + (P >> 31) with an arithmetic shift. P is X·Y, or −X·Y for 0x1 and 0x3. Opcodes 0x2 and 0x3 return the low 32 bits of the sum.
- R3: Saturating opcodes (0x0, 0x1, 0x4, 0x6, 0xE) clamp a sum above 0x7FFFFFFF to 0x7FFFFFFF and a sum below −2^31 to 0x80000000. The clamp sets condition bit 0x10 for that instruction. Every other opcode clears that bit.
- R4: Opcode 0x4 gives A + X·Y as integers with saturation. Opcode 0x5 gives {0, bits 30..0 of A + X·Y}.
- R5: Opcode 0x6 gives A + X + Y with saturation.
- R6: Opcode 0x7 returns A and adds (X·Y >> 31) to the 32-bit accumulator, wrapping on overflow. `acc_value` shows the accumulator one edge later. No other opcode changes it.
- R7: `acc_clear` zeroes the accumulator at the next edge and overrides an opcode 0x7 in the same cycle.
- R8: Opcode 0x8 gives (A & X) ^ Y. Opcode 0x9 gives X when signed A >= Y, and ~X otherwise.
- R9: Opcode 0xA gives X when signed A >= Y, and Y otherwise. Opcode 0xB gives X when signed A < Y, and Y otherwise.
- R10: Opcode 0xE gives A + ((X·(Y − A)) >> 31) with saturation.
- R11: Opcode 0xF returns A. It raises `skip_req` with `skip_count` = X[9:0] when (A & Y) is nonzero. Otherwise `skip_req` and `skip_count` are zero.
- R12: The other condition bits are 0x01 (result bit 31 differs from bit 30), 0x02 (signed A < Y), 0x04 (result bit 31), 0x08 (result zero) and 0x100 (result nonzero). Bits 5–7 are zero.
- R13: `sat_sticky` goes high at the edge that registers a clamped instruction and stays high until `sat_clear` is sampled. A clamp in the same cycle as `sat_clear` wins.
- R14: Opcodes 0xC and 0xD return A, raise no skip and leave the accumulator unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction present this cycle |
| opcode | input | 4 | Operation select |
| op_a | input | 32 | Operand A (signed) |
| op_x | input | 32 | Operand X (signed) |
| op_y | input | 32 | Operand Y (signed) |
| acc_clear | input | 1 | Zero the accumulator |
| sat_clear | input | 1 | Clear the sticky saturation flag |
| out_valid | output | 1 | Result registered this cycle |
| result | output | 32 | Instruction result R |
| ccode | output | 9 | Condition-code word |
| skip_req | output | 1 | Skip request from opcode 0xF |
| skip_count | output | 10 | Number of instructions to skip |
| sat_sticky | output | 1 | Sticky saturation flag |
| acc_value | output | 32 | Internal accumulator |

## Verification
Every product of an instruction is due at the first rising edge after the edge that sampled it: the result, the condition code, the skip fields, a newly set sticky flag and the accumulator update. The bench drives stimulus on falling edges and reads all outputs on the following falling edge, half a cycle after the registers load. A cycle with no instruction is checked at the same point to confirm that `out_valid` has dropped and the result is held. Clears applied alongside an instruction are scored in the same sampling window, so precedence is seen directly at the ports.

// File: rtl/fxdsp_pkg.sv
package fxdsp_pkg;

  localparam int CC_W = 9;

  // condition-code bit positions (software decodes these)
  localparam int CC_NORM   = 0;
  localparam int CC_BORROW = 1;
  localparam int CC_MINUS  = 2;
  localparam int CC_ZERO   = 3;
  localparam int CC_SAT    = 4;
  localparam int CC_NZ     = 8;

  typedef enum logic [3:0] {
    OP_FMAC_S   = 4'h0,
    OP_FMSC_S   = 4'h1,
    OP_FMAC_W   = 4'h2,
    OP_FMSC_W   = 4'h3,
    OP_IMAC_S   = 4'h4,
    OP_IMAC_W31 = 4'h5,
    OP_ADD3_S   = 4'h6,
    OP_ACC_MOVE = 4'h7,
    OP_MASK_XOR = 4'h8,
    OP_CMP_INV  = 4'h9,
    OP_LIM_GE   = 4'hA,
    OP_LIM_LT   = 4'hB,
    OP_CONV_L   = 4'hC,
    OP_CONV_E   = 4'hD,
    OP_INTERP   = 4'hE,
    OP_SKIP     = 4'hF
  } fx_op_e;

endpackage

// File: rtl/fxdsp_mul.sv
module fxdsp_mul #(
  parameter int W = 68
) (
  input  logic signed [W-1:0] mul_a,
  input  logic signed [W-1:0] mul_b,
  output logic signed [W-1:0] mul_p
);
  assign mul_p = mul_a * mul_b;
endmodule

// File: rtl/fxdsp_clamp.sv
module fxdsp_clamp #(
  parameter int DATA_W = 32,
  parameter int WIDE   = 68
) (
  input  logic signed [WIDE-1:0] wide_in,
  output logic [DATA_W-1:0]      clamped,
  output logic                   clipped
);
  localparam logic signed [WIDE-1:0] LIM_HI =
    $signed({{(WIDE-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}});
  localparam logic signed [WIDE-1:0] LIM_LO =
    $signed({{(WIDE-DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}});

  logic over_hi, over_lo;

  always_comb begin
    over_hi = wide_in > LIM_HI;
    over_lo = wide_in < LIM_LO;
    clipped = over_hi | over_lo;
    if (over_hi)      clamped = {1'b0, {(DATA_W-1){1'b1}}};
    else if (over_lo) clamped = {1'b1, {(DATA_W-1){1'b0}}};
    else              clamped = wide_in[DATA_W-1:0];
  end
endmodule

// File: rtl/fxdsp_exec.sv
module fxdsp_exec
  import fxdsp_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 10
) (
  input  fx_op_e             op,
  input  logic [DATA_W-1:0]  a,
  input  logic [DATA_W-1:0]  x,
  input  logic [DATA_W-1:0]  y,
  input  logic [DATA_W-1:0]  acc_cur,
  output logic [DATA_W-1:0]  r,
  output logic               sat,
  output logic               skip,
  output logic [CNT_W-1:0]   skip_cnt,
  output logic [DATA_W-1:0]  acc_next
);
  localparam int WIDE = 2*DATA_W + 4;
  localparam int SH   = DATA_W - 1;
  localparam int EXT  = WIDE - DATA_W;

  logic signed [WIDE-1:0] a_w, x_w, y_w, acc_w, diff_w;
  logic signed [WIDE-1:0] p_xy, p_int, p_mac, frac_mac, frac_pos, frac_int;
  logic signed [WIDE-1:0] wide_sum;
  logic [DATA_W-1:0]      clamped;
  logic                   clipped;
  logic                   a_ge_y;

  always_comb begin
    a_w    = $signed({{EXT{a[DATA_W-1]}}, a});
    x_w    = $signed({{EXT{x[DATA_W-1]}}, x});
    y_w    = $signed({{EXT{y[DATA_W-1]}}, y});
    acc_w  = $signed({{EXT{acc_cur[DATA_W-1]}}, acc_cur});
    diff_w = y_w - a_w;
  end

  fxdsp_mul #(.W(WIDE)) u_mul_xy  (.mul_a(x_w), .mul_b(y_w),    .mul_p(p_xy));
  fxdsp_mul #(.W(WIDE)) u_mul_int (.mul_a(x_w), .mul_b(diff_w), .mul_p(p_int));

  always_comb begin
    p_mac    = (op == OP_FMSC_S || op == OP_FMSC_W) ? -p_xy : p_xy;
    frac_mac = p_mac >>> SH;
    frac_pos = p_xy >>> SH;
    frac_int = p_int >>> SH;
    case (op)
      OP_FMAC_S, OP_FMSC_S,
      OP_FMAC_W, OP_FMSC_W:    wide_sum = a_w + frac_mac;
      OP_IMAC_S, OP_IMAC_W31:  wide_sum = a_w + p_xy;
      OP_ADD3_S:               wide_sum = a_w + x_w + y_w;
      OP_INTERP:               wide_sum = a_w + frac_int;
      default:                 wide_sum = '0;
    endcase
  end

  fxdsp_clamp #(.DATA_W(DATA_W), .WIDE(WIDE)) u_clamp (
    .wide_in(wide_sum), .clamped(clamped), .clipped(clipped)
  );

  always_comb begin
    a_ge_y   = $signed(a) >= $signed(y);
    r        = a;
    sat      = 1'b0;
    skip     = 1'b0;
    skip_cnt = '0;
    acc_next = DATA_W'(acc_w + frac_pos);
    case (op)
      OP_FMAC_S, OP_FMSC_S, OP_IMAC_S,
      OP_ADD3_S, OP_INTERP: begin
        r   = clamped;
        sat = clipped;
      end
      OP_FMAC_W, OP_FMSC_W: r = wide_sum[DATA_W-1:0];
      OP_IMAC_W31:          r = {1'b0, wide_sum[DATA_W-2:0]};
      OP_MASK_XOR:          r = (a & x) ^ y;
      OP_CMP_INV:           r = a_ge_y ? x : ~x;
      OP_LIM_GE:            r = a_ge_y ? x : y;
      OP_LIM_LT:            r = a_ge_y ? y : x;
      OP_SKIP: begin
        skip     = |(a & y);
        skip_cnt = skip ? x[CNT_W-1:0] : '0;
      end
      default:              r = a;
    endcase
  end
endmodule

// File: rtl/fxdsp_ccgen.sv
module fxdsp_ccgen
  import fxdsp_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] r,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] y,
  input  logic              sat,
  output logic [CC_W-1:0]   cc
);
  always_comb begin
    cc            = '0;
    cc[CC_NORM]   = r[DATA_W-1] ^ r[DATA_W-2];
    cc[CC_BORROW] = $signed(a) < $signed(y);
    cc[CC_MINUS]  = r[DATA_W-1];
    cc[CC_ZERO]   = (r == '0);
    cc[CC_SAT]    = sat;
    cc[CC_NZ]     = (r != '0);
  end
endmodule

// File: rtl/fxdsp_alu.sv
module fxdsp_alu
  import fxdsp_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [3:0]        opcode,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_x,
  input  logic [DATA_W-1:0] op_y,
  input  logic              acc_clear,
  input  logic              sat_clear,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic [CC_W-1:0]   ccode,
  output logic              skip_req,
  output logic [CNT_W-1:0]  skip_count,
  output logic              sat_sticky,
  output logic [DATA_W-1:0] acc_value
);
  fx_op_e            op;
  logic [DATA_W-1:0] r_nxt, acc_nxt;
  logic              sat_nxt, skip_nxt;
  logic [CNT_W-1:0]  cnt_nxt;
  logic [CC_W-1:0]   cc_nxt;

  assign op = fx_op_e'(opcode);

  fxdsp_exec #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_exec (
    .op(op), .a(op_a), .x(op_x), .y(op_y), .acc_cur(acc_value),
    .r(r_nxt), .sat(sat_nxt), .skip(skip_nxt), .skip_cnt(cnt_nxt),
    .acc_next(acc_nxt)
  );

  fxdsp_ccgen #(.DATA_W(DATA_W)) u_cc (
    .r(r_nxt), .a(op_a), .y(op_y), .sat(sat_nxt), .cc(cc_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      result     <= '0;
      ccode      <= '0;
      skip_req   <= 1'b0;
      skip_count <= '0;
      sat_sticky <= 1'b0;
      acc_value  <= '0;
    end else begin
      out_valid <= in_valid;
      skip_req  <= in_valid & skip_nxt;
      if (in_valid) begin
        result     <= r_nxt;
        ccode      <= cc_nxt;
        skip_count <= cnt_nxt;
      end else begin
        skip_count <= '0;
      end
      if (in_valid && sat_nxt) sat_sticky <= 1'b1;
      else if (sat_clear)      sat_sticky <= 1'b0;
      if (acc_clear)                           acc_value <= '0;
      else if (in_valid && op == OP_ACC_MOVE)  acc_value <= acc_nxt;
    end
  end
endmodule

// File: rtl/fxdsp_alu_chk.sv
module fxdsp_alu_chk #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [3:0]        opcode,
  input logic [DATA_W-1:0] op_a,
  input logic              acc_clear,
  input logic              sat_clear,
  input logic              out_valid,
  input logic [DATA_W-1:0] result,
  input logic [8:0]        ccode,
  input logic              skip_req,
  input logic [CNT_W-1:0]  skip_count,
  input logic              sat_sticky,
  input logic [DATA_W-1:0] acc_value
);
  localparam logic [DATA_W-1:0] POS_MAX = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] NEG_MAX = {1'b1, {(DATA_W-1){1'b0}}};

  p_latency_r1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_idle_r1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(result) && $stable(ccode)));
  p_clamp_value_r3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && ccode[4]) |-> (result == POS_MAX || result == NEG_MAX));
  p_move_pass_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && opcode == 4'h7) |=> (result == $past(op_a)));
  p_acc_zero_r7: assert property (@(posedge clk) disable iff (rst)
    acc_clear |=> (acc_value == '0));
  p_skip_valid_r11: assert property (@(posedge clk) disable iff (rst)
    skip_req |-> out_valid);
  p_skip_count_r11: assert property (@(posedge clk) disable iff (rst)
    !skip_req |-> (skip_count == '0));
  p_cc_sign_r12: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (ccode[2] == result[DATA_W-1]));
  p_cc_zero_r12: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ((ccode[3] == (result == '0)) && (ccode[8] != ccode[3])));
  p_sticky_hold_r13: assert property (@(posedge clk) disable iff (rst)
    (sat_sticky && !sat_clear) |=> sat_sticky);
  p_sticky_set_r13: assert property (@(posedge clk) disable iff (rst)
    (out_valid && ccode[4]) |-> sat_sticky);
endmodule

bind fxdsp_alu fxdsp_alu_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .opcode(opcode), .op_a(op_a),
  .acc_clear(acc_clear), .sat_clear(sat_clear), .out_valid(out_valid),
  .result(result), .ccode(ccode), .skip_req(skip_req),
  .skip_count(skip_count), .sat_sticky(sat_sticky), .acc_value(acc_value)
);

// File: tb/sim_fxdsp_alu.sv
`timescale 1ns/1ps
module sim_fxdsp_alu;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [3:0]  opcode = '0;
  logic [31:0] op_a = '0, op_x = '0, op_y = '0;
  logic        acc_clear = 1'b0, sat_clear = 1'b0;
  logic        out_valid, skip_req, sat_sticky;
  logic [31:0] result, acc_value;
  logic [8:0]  ccode;
  logic [9:0]  skip_count;

  int  nchk = 0, nfail = 0;
  bit  done = 1'b0;
  logic [31:0] m_acc = '0;
  bit          m_sat = 1'b0;

  always #5 clk = ~clk;

  fxdsp_alu u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .opcode(opcode),
    .op_a(op_a), .op_x(op_x), .op_y(op_y), .acc_clear(acc_clear),
    .sat_clear(sat_clear), .out_valid(out_valid), .result(result),
    .ccode(ccode), .skip_req(skip_req), .skip_count(skip_count),
    .sat_sticky(sat_sticky), .acc_value(acc_value)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic string tag(input logic [3:0] op);
    case (op)
      4'h0, 4'h1, 4'h2, 4'h3: return "R2";
      4'h4, 4'h5:             return "R4";
      4'h6:                   return "R5";
      4'h7:                   return "R6";
      4'h8, 4'h9:             return "R8";
      4'hA, 4'hB:             return "R9";
      4'hE:                   return "R10";
      4'hF:                   return "R11";
      default:                return "R14";
    endcase
  endfunction

  function automatic logic signed [71:0] sx(input logic [31:0] v);
    return $signed({{40{v[31]}}, v});
  endfunction

  function automatic void clampf(input logic signed [71:0] t,
                                 output logic [31:0] r, output bit s);
    s = 1'b1;
    if (t > 72'sd2147483647)       r = 32'h7fffffff;
    else if (t < -72'sd2147483648) r = 32'h80000000;
    else begin r = t[31:0]; s = 1'b0; end
  endfunction

  function automatic void model(input logic [3:0] op,
                                input logic [31:0] a, x, y,
                                output logic [31:0] r, output bit s);
    logic signed [71:0] p, t;
    bit ge;
    ge = $signed(a) >= $signed(y);
    r = a; s = 1'b0;
    case (op)
      4'h0, 4'h1, 4'h2, 4'h3: begin
        p = sx(x) * sx(y);
        if (op[0]) p = -p;
        t = sx(a) + (p >>> 31);
        if (op[1]) r = t[31:0]; else clampf(t, r, s);
      end
      4'h4: clampf(sx(a) + sx(x) * sx(y), r, s);
      4'h5: begin t = sx(a) + sx(x) * sx(y); r = {1'b0, t[30:0]}; end
      4'h6: clampf(sx(a) + sx(x) + sx(y), r, s);
      4'h8: r = (a & x) ^ y;
      4'h9: r = ge ? x : ~x;
      4'hA: r = ge ? x : y;
      4'hB: r = ge ? y : x;
      4'hE: begin
        p = sx(x) * (sx(y) - sx(a));
        clampf(sx(a) + (p >>> 31), r, s);
      end
      default: r = a;
    endcase
  endfunction

  task automatic run_op(input logic [3:0] op, input logic [31:0] a, x, y,
                        input bit aclr, input bit sclr);
    logic [31:0] er;
    bit es, eskip;
    logic [8:0] ecc;
    logic [9:0] ecnt;
    logic signed [71:0] fp;
    string t;
    @(negedge clk);
    in_valid = 1'b1; opcode = op; op_a = a; op_x = x; op_y = y;
    acc_clear = aclr; sat_clear = sclr;
    @(negedge clk);
    in_valid = 1'b0; acc_clear = 1'b0; sat_clear = 1'b0;
    model(op, a, x, y, er, es);
    ecc = {(er != 0), 3'b000, es, (er == 0), er[31],
           ($signed(a) < $signed(y)), (er[31] ^ er[30])};
    eskip = (op == 4'hF) && ((a & y) != 0);
    ecnt = eskip ? x[9:0] : 10'd0;
    fp = (sx(x) * sx(y)) >>> 31;
    if (aclr) m_acc = '0;
    else if (op == 4'h7) m_acc = m_acc + fp[31:0];
    if (es) m_sat = 1'b1;
    else if (sclr) m_sat = 1'b0;
    t = tag(op);
    chk("R1", "out_valid", 64'(out_valid), 64'd1);
    chk(t, $sformatf("result op %h", op), 64'(result), 64'(er));
    chk("R3", "cc saturate bit", 64'(ccode[4]), 64'(es));
    chk("R12", "condition code", 64'(ccode), 64'(ecc));
    chk("R11", "skip request", 64'({skip_req, skip_count}), 64'({eskip, ecnt}));
    chk("R13", "sticky flag", 64'(sat_sticky), 64'(m_sat));
    chk(aclr ? "R7" : "R6", "accumulator", 64'(acc_value), 64'(m_acc));
  endtask

  function automatic logic [31:0] pick();
    case ($urandom % 8)
      0: return 32'h7fffffff;
      1: return 32'h80000000;
      2: return 32'h00000000;
      3: return 32'hffffffff;
      4: return 32'h40000000;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    logic [31:0] held;
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "reset outputs",
        64'({out_valid, result, ccode, skip_req, skip_count, sat_sticky}), 64'd0);
    chk("R6", "reset accumulator", 64'(acc_value), 64'd0);

    // fractional MAC corners, saturate and wrap
    run_op(4'h0, 32'h7fffffff, 32'h40000000, 32'h40000000, 0, 0);
    run_op(4'h0, 32'h00000000, 32'h80000000, 32'h80000000, 0, 0);
    run_op(4'h1, 32'h80000000, 32'h40000000, 32'h40000000, 0, 0);
    run_op(4'h2, 32'h7fffffff, 32'h40000000, 32'h40000000, 0, 0);
    run_op(4'h3, 32'h00000010, 32'h00000003, 32'h80000000, 0, 0);
    // integer MAC and three-way add
    run_op(4'h4, 32'h00000000, 32'h00010000, 32'h00010000, 0, 0);
    run_op(4'h5, 32'h00000005, 32'h00010000, 32'h00010000, 0, 0);
    run_op(4'h6, 32'h7fffffff, 32'h00000001, 32'h00000001, 0, 0);
    // sticky clear ignored when a clamp coincides (R13), then honoured
    run_op(4'h6, 32'h80000000, 32'hffffffff, 32'h00000000, 0, 1);
    run_op(4'h8, 32'h0000ff00, 32'h00ffff00, 32'h000000ff, 0, 1);
    // accumulator move twice, then clear wins over move (R7)
    run_op(4'h7, 32'h12345678, 32'h40000000, 32'h40000000, 0, 0);
    run_op(4'h7, 32'h00000000, 32'h40000000, 32'h40000000, 0, 0);
    run_op(4'h7, 32'h00000001, 32'h40000000, 32'h40000000, 1, 0);
    // compares with equality and both signs
    run_op(4'h9, 32'h00000004, 32'h0000abcd, 32'h00000004, 0, 0);
    run_op(4'h9, 32'hfffffff0, 32'h0000abcd, 32'h00000004, 0, 0);
    run_op(4'hA, 32'h00000004, 32'h00000011, 32'h00000004, 0, 0);
    run_op(4'hB, 32'h00000004, 32'h00000011, 32'h00000004, 0, 0);
    run_op(4'hB, 32'h80000000, 32'h00000011, 32'h00000004, 0, 0);
    // interpolation extremes
    run_op(4'hE, 32'h00000000, 32'h7fffffff, 32'h7fffffff, 0, 0);
    run_op(4'hE, 32'h80000000, 32'h7fffffff, 32'h7fffffff, 0, 0);
    run_op(4'hE, 32'h80000000, 32'h80000000, 32'h7fffffff, 0, 0);
    // skip taken and not taken, converters pass A (R14)
    run_op(4'hF, 32'h00000005, 32'h000003ff, 32'h00000004, 0, 0);
    run_op(4'hF, 32'h00000005, 32'h000003ff, 32'h00000002, 0, 0);
    run_op(4'hC, 32'hdeadbeef, 32'h40000000, 32'h40000000, 0, 0);
    run_op(4'hD, 32'h00000000, 32'h40000000, 32'h40000000, 0, 0);

    // idle cycle: result held, out_valid low (R1)
    held = result;
    @(negedge clk);
    chk("R1", "idle out_valid", 64'(out_valid), 64'd0);
    chk("R1", "idle result hold", 64'(result), 64'(held));

    for (int i = 0; i < 400; i++) begin
      logic [3:0] op;
      op = 4'($urandom % 16);
      run_op(op, pick(), pick(), pick(),
             ($urandom % 16) == 0, ($urandom % 8) == 0);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL R1 watchdog actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule